// File: doc/BRIEF.md
# External Asynchronous Memory Cycle Sequencer

This block turns single read or write requests from on-chip logic into cycles on an external asynchronous memory space with one chip select. A request carries an address, write data, an access size (byte, halfword or longword) and a direction flag. The block then drives the external address, data and control lines through a fixed two-clock bus cycle. The first clock is T1 and the second is T2. When the transfer is complete, it returns a one-cycle done pulse. For a read, it also returns the read data in that same cycle.

The external data bus is 16 or 32 bits wide, set by a parameter. On a 16-bit bus a longword is split into two bus cycles: the upper halfword goes first, at the request address, and the lower halfword goes second, at that address plus 2. Byte lanes follow big-endian order.

A static configuration input selects how the external wait line is handled. In one mode, an idle cycle follows every bus cycle and the wait line is sampled there. In the other mode, the wait line is ignored and the halves of a split access run back to back.

Top module: `extbus_seq`

## Requirements
- R1: After reset, and whenever no request is being served, cs_n, rd_n, bs_n and every we_n line are high, rdwr is high (read state), and req_ready is high.
- R2: Each bus cycle spans two clocks with cs_n low in both. bs_n is low in the first clock (T1) only. bus_addr holds the cycle's address throughout.
- R3: With wait_mode = 0, each bus cycle is followed by at least one clock with cs_n, rd_n and every we_n high, during which ext_wait_n is sampled.
- R4: With wait_mode = 0, if ext_wait_n is sampled low in that idle clock, the idle clock repeats. The next bus cycle, or done, comes only after a high sample, so N low samples give N+1 idle clocks.
- R5: With wait_mode = 1, ext_wait_n has no effect and no idle clock follows a bus cycle. The second half of a split longword starts in the clock right after the first half's T2.
- R6: Size codes are 0 = byte, 1 = halfword, 2 = longword. Lane i of bus_wdata and we_n[i] cover bits 8i+7:8i. On a write, only the lanes holding the written bytes have we_n low, using big-endian lanes:
  - byte at low address k goes to lane 3-k on a 32-bit bus and lane 1-k[0] on a 16-bit bus;
  - a halfword goes to the upper lane pair when address bit 1 is 0.
- R7: rdwr is low only in the two clocks of a write bus cycle. rd_n is low only in the two clocks of a read bus cycle. rd_n and any we_n are never low together.
- R8: On a 16-bit bus, a longword is carried out as two bus cycles. The first uses the request address and carries bits 31:16; the second uses the address plus 2 and carries bits 15:0.
- R9: A read samples the full bus width at the end of T2, whatever the size. rd_data then holds the selected byte or halfword, picked by size and the low address bits in big-endian order and zero-extended, or the whole longword. rd_valid pulses together with done, and only for reads.
- R10: done is a single-clock pulse in the clock after the final bus cycle (or the final idle clock), and req_ready is high in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_mode | input | 1 | 1: ignore wait, no idle clock; 0: idle clock with wait sampling |
| req_valid | input | 1 | Request present, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 longword |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| done | output | 1 | One-clock completion pulse |
| rd_valid | output | 1 | rd_data valid, pulses with done on reads |
| rd_data | output | 32 | Read data, zero-extended |
| bus_addr | output | ADDR_W | External address |
| bus_wdata | output | BUS_W | External write data |
| ext_rdata | input | BUS_W | External read data |
| ext_wait_n | input | 1 | Active-low external wait |
| cs_n | output | 1 | Active-low chip select |
| rdwr | output | 1 | Direction, high = read |
| rd_n | output | 1 | Active-low read strobe |
| we_n | output | BUS_W/8 | Active-low per-lane write enables |
| bs_n | output | 1 | Active-low bus-cycle start strobe |

## Verification
The bench sweeps both directions, every size, and every aligned low-address offset. Each combination runs in both wait modes and with zero or two low wait samples. Varying the offset separates the byte and halfword lane choices on the write enables and in read extraction. Longwords show the split into two cycles, the address step and the halfword order. Driving wait low in the mode that ignores it, against the mode that honours it, shows whether idle clocks are inserted and stretched only when they should be. Read and write runs of the same size show that the strobes and direction line never overlap.

// File: rtl/extbus_seq.sv
module extbus_seq #(
  parameter int ADDR_W = 26,
  parameter bit BUS32  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wait_mode,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     req_ready,
  output logic                     done,
  output logic                     rd_valid,
  output logic [31:0]              rd_data,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [(BUS32?32:16)-1:0] bus_wdata,
  input  logic [(BUS32?32:16)-1:0] ext_rdata,
  input  logic                     ext_wait_n,
  output logic                     cs_n,
  output logic                     rdwr,
  output logic                     rd_n,
  output logic [(BUS32?4:2)-1:0]   we_n,
  output logic                     bs_n
);
  localparam int BUS_W = BUS32 ? 32 : 16;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2, S_NOP} st_t;

  st_t               st;
  logic              wr_q, wm_q, second_q, done_q, rdv_q;
  logic [1:0]        sz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       wd_q, rbuf;

  wire        is_long = sz_q[1];
  wire        split   = is_long && !BUS32;
  wire        last    = !split || second_q;
  wire        in_acc  = (st == S_T1) || (st == S_T2);
  wire [1:0]  lo      = BUS32 ? addr_q[1:0] : {1'b0, addr_q[0]};
  wire [31:0] ext32   = 32'(ext_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      wm_q     <= 1'b0;
      second_q <= 1'b0;
      done_q   <= 1'b0;
      rdv_q    <= 1'b0;
      sz_q     <= 2'd0;
      addr_q   <= '0;
      wd_q     <= '0;
      rbuf     <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          wm_q     <= wait_mode;
          sz_q     <= req_size;
          addr_q   <= req_addr;
          wd_q     <= req_wdata;
          second_q <= 1'b0;
          st       <= S_T1;
        end
        S_T1: st <= S_T2;
        S_T2: begin
          if (!wr_q) begin
            if (BUS32)         rbuf        <= ext32;
            else if (second_q) rbuf[15:0]  <= ext32[15:0];
            else               rbuf[31:16] <= ext32[15:0];
          end
          if (!wm_q) st <= S_NOP;
          else if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            rdv_q  <= !wr_q;
          end else begin
            second_q <= 1'b1;
            st       <= S_T1;
          end
        end
        S_NOP: if (ext_wait_n) begin
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            rdv_q  <= !wr_q;
          end else begin
            second_q <= 1'b1;
            st       <= S_T1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [3:0]  mask4;
  logic [31:0] wd32, wsel;
  logic [7:0]  rbyte;

  always_comb begin
    if (is_long)          mask4 = 4'b1111;
    else if (sz_q == 2'd1) mask4 = lo[1] ? 4'b0011 : 4'b1100;
    else                  mask4 = 4'b1000 >> lo;
  end

  always_comb begin
    if (is_long)           wd32 = wd_q;
    else if (sz_q == 2'd1) wd32 = {2{wd_q[15:0]}};
    else                   wd32 = {4{wd_q[7:0]}};
    if (BUS32)         wsel = wd32;
    else if (second_q) wsel = {16'h0, wd32[15:0]};
    else               wsel = {16'h0, wd32[31:16]};
  end

  always_comb begin
    case (lo)
      2'd0:    rbyte = rbuf[31:24];
      2'd1:    rbyte = rbuf[23:16];
      2'd2:    rbyte = rbuf[15:8];
      default: rbyte = rbuf[7:0];
    endcase
    if (is_long)           rd_data = rbuf;
    else if (sz_q == 2'd1) rd_data = {16'h0, lo[1] ? rbuf[15:0] : rbuf[31:16]};
    else                   rd_data = {24'h0, rbyte};
  end

  assign req_ready = (st == S_IDLE);
  assign done      = done_q;
  assign rd_valid  = rdv_q;
  assign bus_addr  = second_q ? addr_q + ADDR_W'(2) : addr_q;
  assign bus_wdata = wsel[BUS_W-1:0];
  assign cs_n      = !in_acc;
  assign bs_n      = (st != S_T1);
  assign rdwr      = !(in_acc && wr_q);
  assign rd_n      = !(in_acc && !wr_q);
  assign we_n      = (in_acc && wr_q) ? ~mask4[3 -: LANES] : '1;
endmodule

module extbus_seq_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_mode,
  input logic             ext_wait_n,
  input logic             req_ready,
  input logic             done,
  input logic             rd_valid,
  input logic             cs_n,
  input logic             rdwr,
  input logic             rd_n,
  input logic [LANES-1:0] we_n,
  input logic             bs_n
);
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !(&we_n)));
  a_r2_bs_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |-> !cs_n);
  a_r2_bs_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |=> bs_n);
  a_r2_cs_two_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    !bs_n |=> !cs_n);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  a_r9_rdv_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);
  a_r1_rdwr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> rdwr);
  a_r3_idle_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_mode && !cs_n && bs_n) |=> cs_n);
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_mode && cs_n && !req_ready && !ext_wait_n) |=> (cs_n && !done));
endmodule

bind extbus_seq extbus_seq_chk #(.LANES(BUS32 ? 4 : 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .ext_wait_n(ext_wait_n),
  .req_ready(req_ready), .done(done), .rd_valid(rd_valid), .cs_n(cs_n),
  .rdwr(rdwr), .rd_n(rd_n), .we_n(we_n), .bs_n(bs_n)
);

// File: tb/test_extbus_seq.sv
module test_extbus_seq;
  localparam int ADDR_W = 26;
  localparam bit BUS32  = 1'b0;
  localparam int BUS_W  = BUS32 ? 32 : 16;
  localparam int LANES  = BUS_W / 8;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              wait_mode = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [BUS_W-1:0]  ext_rdata = '0;
  logic              ext_wait_n = 1'b1;
  logic              req_ready, done, rd_valid, cs_n, rdwr, rd_n, bs_n;
  logic [31:0]       rd_data;
  logic [ADDR_W-1:0] bus_addr;
  logic [BUS_W-1:0]  bus_wdata;
  logic [LANES-1:0]  we_n;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  extbus_seq #(.ADDR_W(ADDR_W), .BUS32(BUS32)) i_extbus_seq (
    .clk(clk), .rst_n(rst_n), .wait_mode(wait_mode), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_rdata(ext_rdata), .ext_wait_n(ext_wait_n),
    .cs_n(cs_n), .rdwr(rdwr), .rd_n(rd_n), .we_n(we_n), .bs_n(bs_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string tag);
    check(cs_n && rd_n && bs_n && rdwr && (&we_n) && req_ready, tag,
          {26'h0, cs_n, rd_n, bs_n, rdwr, &we_n, req_ready}, 32'h3f);
  endtask

  function automatic logic [31:0] rword(input int k, input int h);
    return 32'hC0DE5A00 ^ (k << 8) ^ (h * 32'h00110011);
  endfunction

  function automatic logic [3:0] exp_mask(input logic [1:0] s, input logic [1:0] lo);
    if (BUS32) begin
      if (s == 2) return 4'hf;
      if (s == 1) return lo[1] ? 4'b0011 : 4'b1100;
      return 4'b1000 >> lo;
    end
    if (s == 0) return lo[0] ? 4'b0001 : 4'b0010;
    return 4'b0011;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] s, input logic [31:0] w, input int h);
    if (s == 0) return BUS32 ? {4{w[7:0]}} : {16'h0, {2{w[7:0]}}};
    if (s == 1) return BUS32 ? {2{w[15:0]}} : {16'h0, w[15:0]};
    if (BUS32) return w;
    return h == 0 ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] s, input logic [1:0] lo, input int k);
    logic [31:0] full;
    if (BUS32) full = rword(k, 0);
    else       full = {rword(k, 0)[15:0], rword(k, 1)[15:0]};
    if (!BUS32 && s != 2) begin
      if (s == 1) return {16'h0, full[31:16]};
      return {24'h0, lo[0] ? full[23:16] : full[31:24]};
    end
    if (s == 2) return full;
    if (s == 1) return {16'h0, lo[1] ? full[15:0] : full[31:16]};
    return {24'h0, full[8*(3-lo) +: 8]};
  endfunction

  task automatic run(input bit wr, input logic [1:0] s, input logic [1:0] lo,
                     input bit wm, input int nw, input int k);
    logic [ADDR_W-1:0] a;
    logic [31:0] w;
    logic [LANES-1:0] m;
    int halves;
    a = ADDR_W'(32'h0ABC00 + (k << 4)) | ADDR_W'(lo);
    w = 32'hA1B2C3D4 ^ (k * 32'h01010101);
    m = exp_mask(s, lo)[LANES-1:0];
    halves = (s == 2 && !BUS32) ? 2 : 1;
    wait_mode = wm; req_write = wr; req_size = s; req_addr = a; req_wdata = w;
    ext_wait_n = wm ? 1'b0 : 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int h = 0; h < halves; h++) begin
      ext_rdata = rword(k, h)[BUS_W-1:0];
      // T1
      check(!cs_n && !bs_n && !req_ready, "R2 T1 strobes", {29'h0, cs_n, bs_n, req_ready}, 0);
      check(bus_addr == (h == 0 ? a : a + 2), "R8 address", 32'(bus_addr), 32'(h == 0 ? a : a + 2));
      check(rdwr == !wr && rd_n == wr, "R7 direction/read strobe", {30'h0, rdwr, rd_n}, {30'h0, !wr, wr});
      check(we_n == (wr ? ~m : '1), "R6 write enables", 32'(we_n), 32'(wr ? ~m : {LANES{1'b1}}));
      if (wr) check(32'(bus_wdata) == exp_wd(s, w, h), "R8 write data", 32'(bus_wdata), exp_wd(s, w, h));
      check(!done, "R10 no early done", 32'(done), 0);
      @(negedge clk);
      // T2
      check(!cs_n && bs_n, "R2 T2 strobes", {30'h0, cs_n, bs_n}, 32'h1);
      check(rd_n == wr && we_n == (wr ? ~m : '1), "R7 T2 strobes", {rd_n, 31'(we_n)}, {wr, 31'(wr ? ~m : {LANES{1'b1}})});
      if (!wm) begin
        for (int j = 0; j <= nw; j++) begin
          @(negedge clk);
          check(cs_n && rd_n && (&we_n) && rdwr && !done, (j == 0) ? "R3 idle clock" : "R4 wait extends",
                {27'h0, cs_n, rd_n, &we_n, rdwr, done}, 32'h1e);
          ext_wait_n = (j < nw) ? 1'b0 : 1'b1;
        end
      end
      @(negedge clk);
      if (h + 1 < halves)
        check(!cs_n && !bs_n, wm ? "R5 back-to-back halves" : "R8 second half", {30'h0, cs_n, bs_n}, 0);
    end
    check(done && req_ready && cs_n, "R10 done pulse", {29'h0, done, req_ready, cs_n}, 32'h7);
    check(rd_valid == !wr, "R9 rd_valid", 32'(rd_valid), 32'(!wr));
    if (!wr) check(rd_data == exp_rd(s, lo, k), "R9 read data", rd_data, exp_rd(s, lo, k));
    @(negedge clk);
    check(!done && !rd_valid, "R10 single pulse", {30'h0, done, rd_valid}, 0);
    idle_check("R1 idle between requests");
    ext_wait_n = 1'b1;
  endtask

  initial begin
    int k;
    k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 reset state");
    for (int wr = 0; wr < 2; wr++)
      for (int s = 0; s < 3; s++)
        for (int lo = 0; lo < 4; lo++)
          for (int wm = 0; wm < 2; wm++)
            for (int nw = 0; nw < 3; nw += 2) begin
              if ((s == 1 && lo[0]) || (s == 2 && lo != 0)) continue;
              run(wr[0], s[1:0], lo[1:0], wm[0], nw, k);
              k++;
            end
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule